// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the effective address for each beat of a short burst in a synchronous memory interface. A load cycle captures a full base address. Each advance cycle then steps only the low burst-index bits, while the upper bits stay at their loaded value. The stepping order is chosen by a static strap: wrap-around linear counting or XOR-based interleaving. With the default two index bits, a burst has four beats, and the fifth address equals the base again.

A clock-enable input freezes the sequence and its stored base. A load cycle that arrives without the chip-select result deselects the sequencer. While deselected, advance cycles do nothing until a selected load arrives. The address output comes straight from registers, so it changes only after a rising clock edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low at a rising edge, addr_out becomes 0 after that edge.
- R2: An edge with clk_en=1, advance=0 and sel=1 loads the base, and addr_out equals the sampled addr_in after that edge.
- R3: With mode_ilv=0 (linear), the low two bits of addr_out after the k-th advance since a load are (b+k) mod 4, where b is the low two bits of the base.
- R4: With mode_ilv=1 (interleaved), the low two bits of addr_out after the k-th advance are b XOR (k mod 4).
- R5: After four advances in either order, addr_out equals the loaded base again.
- R6: An edge with clk_en=0 leaves the burst position and the base unchanged, whatever advance, sel and addr_in carry.
- R7: An edge with clk_en=1, advance=0 and sel=0 deselects the sequencer and leaves addr_out unchanged. Later advance edges leave addr_out unchanged until a load with sel=1 occurs.
- R8: Advance edges never change the upper address bits [17:2]. addr_in is ignored on advance edges.
- R9: mode_ilv is sampled on every rising edge, including edges with clk_en=0. After an edge that samples a new mode, the low bits reflect the new order applied to the same beat count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Clock qualifier, 1 = edge is acted on |
| advance | input | 1 | 1 = step burst, 0 = load (or deselect when sel=0) |
| sel | input | 1 | Chip-select result, 1 = selected |
| mode_ilv | input | 1 | Order strap, 0 = linear, 1 = interleaved |
| addr_in | input | 18 | Full external address |
| addr_out | output | 18 | Current effective address |

## Verification
The bench uses bases whose low bits are nonzero and near the wrap point, so a counter that fails to wrap modulo four, or that uses addition where XOR is needed, produces a wrong fourth beat or fails to return to the base. During advance and stall cycles it changes addr_in, so a design that lets the live input leak into the upper bits, or that keeps counting while clock enable is low, shows a changed address. It deselects the sequencer and then keeps advancing, which catches a design that still steps without a fresh load. It also flips the strap during a stalled cycle, which catches a design that samples the mode only on enabled edges.

// File: rtl/burst_addr_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes: a single order strap bit; encoding is fixed below.
package burst_addr_pkg;
    // Burst stepping order, as seen on the mode_ilv pin.
    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_base_reg.sv
// Module: burst_base_reg
// Holds the base address captured on a selected load cycle.
// Assumes: load_sel is already qualified by clock enable.
module burst_base_reg #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_q
);
    // Capture the external address on a selected load, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (load_sel) begin
            base_q <= addr_in;
        end
    end
endmodule

// File: rtl/burst_beat_ctr.sv
// Module: burst_beat_ctr
// Counts beats since the last selected load, modulo 2**CNT_W, and tracks
// whether the sequencer is armed (selected load seen since the last deselect).
// Assumes: all control inputs are already qualified by clock enable.
module burst_beat_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_sel,
    input  logic             deselect,
    input  logic             step,
    output logic [CNT_W-1:0] beat_q,
    output logic             armed_q
);
    // Restart on a selected load, disarm on deselect, step only when armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q  <= '0;
            armed_q <= 1'b0;
        end else if (load_sel) begin
            beat_q  <= '0;
            armed_q <= 1'b1;
        end else if (deselect) begin
            armed_q <= 1'b0;
        end else if (step && armed_q) begin
            beat_q  <= beat_q + 1'b1;
        end
    end
endmodule

// File: rtl/burst_order_map.sv
// Module: burst_order_map
// Maps base low bits and beat count to the effective low bits in the
// selected order. Purely combinational.
// Assumes: wrap-around is modulo 2**CNT_W in both orders.
module burst_order_map #(
    parameter int CNT_W = 2
) (
    input  burst_addr_pkg::burst_order_e order,
    input  logic [CNT_W-1:0]             base_lo,
    input  logic [CNT_W-1:0]             beat,
    output logic [CNT_W-1:0]             eff_lo
);
    logic [CNT_W-1:0] lin_lo;
    logic [CNT_W-1:0] ilv_lo;

    // Linear order: add beat to base and drop the carry out.
    always_comb begin
        lin_lo = base_lo + beat;
    end

    // Interleaved order: each bit is flipped by the matching beat bit.
    for (genvar i = 0; i < CNT_W; i++) begin : g_ilv
        assign ilv_lo[i] = base_lo[i] ^ beat[i];
    end

    // Select the order named by the strap.
    always_comb begin
        eff_lo = (order == burst_addr_pkg::ORDER_INTERLEAVED) ? ilv_lo : lin_lo;
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst_addr_gen (top)
// Burst address sequencer: loads a base address, then steps the low CNT_W
// bits in linear or interleaved order; upper bits come from the base.
// Assumes: mode_ilv is a static strap, sampled on every rising edge.
module burst_addr_gen #(
    parameter int ADDR_W = 18,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              advance,
    input  logic              sel,
    input  logic              mode_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    import burst_addr_pkg::*;

    localparam int HI_W = ADDR_W - CNT_W;

    logic                 load_sel;
    logic                 deselect;
    logic                 step;
    logic [ADDR_W-1:0]    base_q;
    logic [CNT_W-1:0]     beat_q;
    logic                 armed_q;
    logic [CNT_W-1:0]     eff_lo;
    burst_order_e         order_q;

    // Decode the qualified cycle type from clock enable and advance/load.
    always_comb begin
        load_sel = clk_en && !advance && sel;
        deselect = clk_en && !advance && !sel;
        step     = clk_en && advance;
    end

    // Track the order strap on every edge, reset included.
    always_ff @(posedge clk) begin
        order_q <= burst_order_e'(mode_ilv);
    end

    burst_base_reg #(
        .ADDR_W (ADDR_W)
    ) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_sel (load_sel),
        .addr_in  (addr_in),
        .base_q   (base_q)
    );

    burst_beat_ctr #(
        .CNT_W (CNT_W)
    ) u_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_sel (load_sel),
        .deselect (deselect),
        .step     (step),
        .beat_q   (beat_q),
        .armed_q  (armed_q)
    );

    burst_order_map #(
        .CNT_W (CNT_W)
    ) u_map (
        .order   (order_q),
        .base_lo (base_q[CNT_W-1:0]),
        .beat    (beat_q),
        .eff_lo  (eff_lo)
    );

    // Join the held upper bits with the mapped low bits.
    always_comb begin
        addr_out = {base_q[ADDR_W-1:CNT_W], eff_lo};
    end

    // armed_q only gates stepping inside the counter.
    logic unused_armed;
    always_comb begin
        unused_armed = armed_q;
    end

    logic [HI_W-1:0] unused_hi_w;
    always_comb begin
        unused_hi_w = '0;
    end
endmodule

// File: rtl/burst_addr_gen_chk.sv
// Module: burst_addr_gen_chk
// Assertion checker bound to burst_addr_gen; observes ports only.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 18,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              advance,
    input logic              sel,
    input logic              mode_ilv,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out
);
    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> addr_out == '0);

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !advance && sel) |=> addr_out == $past(addr_in));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W]));

    // R7
    deselect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !advance && !sel && $stable(mode_ilv)) |=> $stable(addr_out));

    // R8
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && advance) |=> addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .advance  (advance),
    .sel      (sel),
    .mode_ilv (mode_ilv),
    .addr_in  (addr_in),
    .addr_out (addr_out)
);

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b0;
    logic          advance = 1'b0;
    logic          sel = 1'b0;
    logic          mode_ilv = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    burst_addr_gen u_burst_addr_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .advance  (advance),
        .sel      (sel),
        .mode_ilv (mode_ilv),
        .addr_in  (addr_in),
        .addr_out (addr_out)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%05h exp=%05h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, sample 1 ns after the rising edge.
    task automatic cyc(input logic en, input logic adv, input logic s, input logic [AW-1:0] a);
        @(negedge clk);
        clk_en = en; advance = adv; sel = s; addr_in = a;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [AW-1:0] lin(input logic [AW-1:0] b, input int k);
        return {b[AW-1:2], 2'((int'(b[1:0]) + k) % 4)};
    endfunction

    function automatic logic [AW-1:0] ilv(input logic [AW-1:0] b, input int k);
        return {b[AW-1:2], b[1:0] ^ 2'(k % 4)};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) cyc(1'b1, 1'b0, 1'b1, 18'h3FFFF);
        check("R1 reset", addr_out, '0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_linear(input logic [AW-1:0] b);
        mode_ilv = 1'b0;
        cyc(1'b1, 1'b0, 1'b1, b);
        check("R2 load", addr_out, b);
        for (int k = 1; k <= 4; k++) begin
            cyc(1'b1, 1'b1, 1'b1, ~b);
            check((k == 4) ? "R5 linear wrap" : "R3 linear step R8", addr_out, lin(b, k));
        end
    endtask

    task automatic t_interleave(input logic [AW-1:0] b);
        mode_ilv = 1'b1;
        cyc(1'b1, 1'b0, 1'b1, b);
        cyc(1'b1, 1'b0, 1'b1, b);
        check("R2 load", addr_out, b);
        for (int k = 1; k <= 4; k++) begin
            cyc(1'b1, 1'b1, 1'b1, b ^ 18'h2AAAA);
            check((k == 4) ? "R5 interleaved wrap" : "R4 interleaved step R8", addr_out, ilv(b, k));
        end
        mode_ilv = 1'b0;
        cyc(1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic t_stall();
        logic [AW-1:0] b = 18'h1C7F6;
        mode_ilv = 1'b0;
        cyc(1'b1, 1'b0, 1'b1, b);
        cyc(1'b1, 1'b1, 1'b1, '0);
        check("R3 stall pre", addr_out, lin(b, 1));
        cyc(1'b0, 1'b1, 1'b1, 18'h00001);
        cyc(1'b0, 1'b0, 1'b1, 18'h3ABCD);
        cyc(1'b0, 1'b0, 1'b0, 18'h12345);
        check("R6 stall hold", addr_out, lin(b, 1));
        cyc(1'b1, 1'b1, 1'b1, '0);
        check("R6 resume", addr_out, lin(b, 2));
    endtask

    task automatic t_deselect();
        logic [AW-1:0] b = 18'h0F0F1;
        mode_ilv = 1'b0;
        cyc(1'b1, 1'b0, 1'b1, b);
        cyc(1'b1, 1'b1, 1'b1, '0);
        cyc(1'b1, 1'b0, 1'b0, 18'h33333);
        check("R7 deselect hold", addr_out, lin(b, 1));
        cyc(1'b1, 1'b1, 1'b1, '0);
        cyc(1'b1, 1'b1, 1'b0, '0);
        check("R7 no step when disarmed", addr_out, lin(b, 1));
        cyc(1'b1, 1'b0, 1'b1, 18'h22222);
        cyc(1'b1, 1'b1, 1'b1, '0);
        check("R7 rearmed", addr_out, lin(18'h22222, 1));
    endtask

    task automatic t_mode_switch();
        logic [AW-1:0] b = 18'h15551;
        mode_ilv = 1'b0;
        cyc(1'b1, 1'b0, 1'b1, b);
        cyc(1'b1, 1'b1, 1'b1, '0);
        check("R9 linear beat", addr_out, lin(b, 1));
        mode_ilv = 1'b1;
        cyc(1'b0, 1'b1, 1'b1, '0);
        check("R9 mode on stalled edge", addr_out, ilv(b, 1));
        cyc(1'b1, 1'b1, 1'b1, '0);
        check("R9 interleaved continue", addr_out, ilv(b, 2));
        mode_ilv = 1'b0;
        cyc(1'b0, 1'b0, 1'b0, '0);
    endtask

    initial begin
        t_reset();
        t_linear(18'h2A5F3);
        t_linear(18'h10001);
        t_interleave(18'h3C002);
        t_interleave(18'h0ABC3);
        t_stall();
        t_deselect();
        t_mode_switch();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule